// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit sits between a processor's data-access port and a memory that is one 32-bit word wide. Each request carries a byte address, an access size (single byte or full word), a read/write flag and store data. The unit turns the request into a word address, a byte-enable mask and lane-steered store data. Returned words are narrowed to a sign-extended byte, or passed through whole, on the way back.

Lanes follow big-endian order. The byte at the lowest address of a word is its most-significant byte. A full-word access must be aligned to a multiple of four. An unaligned word request is dropped before it reaches memory and is reported as an error. Memory is expected to answer a read with its data one clock after the request, as a synchronous block RAM does. Load results therefore appear one cycle after the request, with a valid strobe.

Top module: `bel_lsu`

## Requirements
- R1: For every request that reaches memory, `mem_addr` equals `req_addr` with its two low bits removed.
- R2: An aligned word store (`req_word`=1, `req_addr[1:0]`=00) drives `mem_we`=1, `mem_be`=4'b1111 and `mem_wdata` equal to `req_wdata` in the same cycle.
- R3: A byte store at any offset drives `mem_we`=1, places `req_wdata[7:0]` on all four byte lanes of `mem_wdata`, and sets exactly one `mem_be` bit: offset 0 sets bit 3, offset 1 bit 2, offset 2 bit 1, offset 3 bit 0. Byte accesses never raise `err`.
- R4: An aligned word load drives `mem_re`=1 and `mem_be`=4'b1111. In the next cycle `ld_valid`=1 and `ld_data` equals the whole word from memory. `ld_data` is zero whenever `ld_valid` is low.
- R5: A byte load at offset k drives `mem_re`=1 with the same single enable bit as R3. In the next cycle `ld_valid`=1 and `ld_data[7:0]` holds memory bits [31-8k:24-8k].
- R6: On a byte load, `ld_data[31:8]` are all copies of bit 7 of the selected byte: all ones for a negative byte and all zeros otherwise.
- R7: A word request with `req_addr[1:0]` not 00 drives `mem_we`=0, `mem_re`=0 and `mem_be`=0 in its own cycle. In the next cycle `err`=1 and `ld_valid`=0.
- R8: In a cycle with `req_valid`=0, `mem_we`, `mem_re` and `mem_be` are 0, and in the next cycle `ld_valid`=0 and `err`=0.
- R9: While `rst` is high, and in the first cycle after it, `ld_valid` and `err` are 0, whatever the request inputs do.
- R10: A byte store changes only the addressed byte in memory. A later word load returns the other three bytes as they were before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = full word, 0 = single byte |
| req_addr | input | AW (16) | Byte address |
| req_wdata | input | DW (32) | Store data; bits [7:0] for a byte store |
| mem_addr | output | AW-2 (14) | Word address to memory |
| mem_be | output | DW/8 (4) | Byte enables, bit 3 = most-significant lane |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW (32) | Lane-steered store data |
| mem_rdata | input | DW (32) | Word returned by memory one cycle after `mem_re` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | DW (32) | Load result |
| err | output | 1 | Misaligned word request seen last cycle |

## Verification
Two things can happen in the same cycle: a load result returns for the previous request, and a new request is steered to memory. The bench provokes this with back-to-back load-then-store, load-then-misaligned and store-then-load sequences, followed by a long randomized stream with few idle gaps. A behavioural shadow memory in the bench predicts every cycle. The returned value must reflect memory before the following store. `err` and `ld_valid` must each belong to the request one cycle earlier, never to the current one.

// File: rtl/bel_lsu_pkg.sv
package bel_lsu_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;

  function automatic logic [31:0] sext_byte(input logic [BYTE_W-1:0] b);
    return {{(32-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction
endpackage

// File: rtl/bel_store_steer.sv
module bel_store_steer #(
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int OFFW  = $clog2(LANES)
) (
  input  logic                   word_i,
  input  logic [OFFW-1:0]        off_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [LANES-1:0]       be_o,
  output logic [DW-1:0]          wdata_o,
  output logic                   misalign_o
);
  logic [LANES-1:0] lane_hit;

  // Big-endian: offset k lands on lane LANES-1-k (lane 0 = bits [7:0]).
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LN = LANES - 1 - k;
    assign lane_hit[LN] = (off_i == OFFW'(k));
    assign wdata_o[LN*8 +: 8] = word_i ? wdata_i[LN*8 +: 8] : wdata_i[7:0];
  end

  assign misalign_o = word_i && (off_i != '0);
  assign be_o       = word_i ? {LANES{1'b1}} : lane_hit;
endmodule

// File: rtl/bel_load_extract.sv
module bel_load_extract #(
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int OFFW  = $clog2(LANES)
) (
  input  logic            word_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [DW-1:0]   data_o
);
  logic [7:0] byte_at [LANES];
  logic [7:0] sel;

  for (genvar k = 0; k < LANES; k++) begin : g_pick
    assign byte_at[k] = rdata_i[(LANES-1-k)*8 +: 8];
  end

  assign sel    = byte_at[off_i];
  assign data_o = word_i ? rdata_i : {{(DW-8){sel[7]}}, sel};
endmodule

// File: rtl/bel_lsu.sv
module bel_lsu #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_word,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic [AW-$clog2(DW/8)-1:0] mem_addr,
  output logic [DW/8-1:0]           mem_be,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [DW-1:0]             mem_wdata,
  input  logic [DW-1:0]             mem_rdata,
  output logic                      ld_valid,
  output logic [DW-1:0]             ld_data,
  output logic                      err
);
  import bel_lsu_pkg::*;

  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  typedef struct packed {
    acc_size_e       size;
    logic [OFFW-1:0] off;
  } ld_ctx_t;

  logic [OFFW-1:0]  off;
  logic [LANES-1:0] be_raw;
  logic             misalign;
  logic             go;
  ld_ctx_t          ctx_q;
  logic [DW-1:0]    shaped;

  assign off = req_addr[OFFW-1:0];

  bel_store_steer #(.DW(DW)) steer_i (
    .word_i     (req_word),
    .off_i      (off),
    .wdata_i    (req_wdata),
    .be_o       (be_raw),
    .wdata_o    (mem_wdata),
    .misalign_o (misalign)
  );

  assign go       = req_valid && !misalign;
  assign mem_addr = req_addr[AW-1:OFFW];
  assign mem_we   = go && req_write;
  assign mem_re   = go && !req_write;
  assign mem_be   = go ? be_raw : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      err      <= 1'b0;
      ctx_q    <= '{size: ACC_BYTE, off: '0};
    end else begin
      ld_valid <= mem_re;
      err      <= req_valid && misalign;
      if (mem_re) begin
        ctx_q.size <= req_word ? ACC_WORD : ACC_BYTE;
        ctx_q.off  <= off;
      end
    end
  end

  bel_load_extract #(.DW(DW)) extract_i (
    .word_i  (ctx_q.size == ACC_WORD),
    .off_i   (ctx_q.off),
    .rdata_i (mem_rdata),
    .data_o  (shaped)
  );

  assign ld_data = ld_valid ? shaped : '0;
endmodule

// File: rtl/bel_lsu_chk.sv
module bel_lsu_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_write,
  input logic                       req_word,
  input logic [AW-1:0]              req_addr,
  input logic [DW/8-1:0]            mem_be,
  input logic                       mem_we,
  input logic                       mem_re,
  input logic                       ld_valid,
  input logic [DW-1:0]              ld_data,
  input logic                       err
);
  localparam int OFFW = $clog2(DW/8);

  logic aligned;
  assign aligned = (req_addr[OFFW-1:0] == '0);

  // R2
  word_store_full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_word && aligned) |-> (mem_we && (&mem_be)));

  // R3
  byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_word) |-> (mem_we && $countones(mem_be) == 1));

  // R4
  load_returns_next_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && (aligned || !req_word)) |=> ld_valid);

  // R7
  misalign_blocks_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_word && !aligned) |-> (!mem_we && !mem_re && mem_be == '0));

  // R7
  misalign_flags_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_word && !aligned) |=> (err && !ld_valid));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ld_valid && !err));

  // R4
  data_zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |-> (ld_data == '0));

  // R8
  no_strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

bind bel_lsu bel_lsu_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_word  (req_word),
  .req_addr  (req_addr),
  .mem_be    (mem_be),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data),
  .err       (err)
);

// File: tb/bel_lsu_tb_top.sv
module bel_lsu_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        req_valid, req_write, req_word;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic [AW-3:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re;
  logic [31:0] mem_wdata, mem_rdata;
  logic        ld_valid, err;
  logic [31:0] ld_data;

  bel_lsu #(.AW(AW), .DW(32)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .err(err)
  );

  // Synchronous memory seen by the unit.
  logic [31:0] bmem [256];
  logic [31:0] rdata_q;
  assign mem_rdata = rdata_q;
  always @(posedge clk) begin
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) bmem[mem_addr[7:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
    if (mem_re) rdata_q <= bmem[mem_addr[7:0]];
  end

  // Reference model state.
  logic [31:0] refm [256];
  int compared = 0;
  int mismatched = 0;
  bit exp_lv = 0, exp_err = 0;
  logic [31:0] exp_ld = 0;
  string nxt_tag = "R9";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit w, input bit word, input int addr,
                      input logic [31:0] wd);
    int off, wa;
    bit mis, ewe, ere;
    logic [3:0] ebe;
    logic [31:0] ewd, cur;
    logic [7:0] b;
    @(negedge clk);
    // Results of the previous request.
    check({nxt_tag, " ld_valid"}, {31'd0, ld_valid}, {31'd0, exp_lv});
    check({nxt_tag, " err"}, {31'd0, err}, {31'd0, exp_err});
    check({nxt_tag, " ld_data"}, ld_data, exp_ld);
    // New request.
    req_valid = v; req_write = w; req_word = word;
    req_addr = AW'(addr); req_wdata = wd;
    off = addr % 4; wa = addr / 4;
    mis = word && (off != 0);
    ewe = v && w && !mis;
    ere = v && !w && !mis;
    ebe = (!v || mis) ? 4'd0 : (word ? 4'hF : 4'(8 >> off));
    ewd = word ? wd : {4{wd[7:0]}};
    #1;
    if (!v) begin
      check("R8 mem_we", {31'd0, mem_we}, 0);
      check("R8 mem_re", {31'd0, mem_re}, 0);
      check("R8 mem_be", {28'd0, mem_be}, 0);
    end else if (mis) begin
      check("R7 mem_we", {31'd0, mem_we}, 0);
      check("R7 mem_re", {31'd0, mem_re}, 0);
      check("R7 mem_be", {28'd0, mem_be}, 0);
    end else begin
      check(w ? (word ? "R2 mem_we" : "R3 mem_we") : "R4/R5 mem_we", {31'd0, mem_we}, {31'd0, ewe});
      check(w ? "R2/R3 mem_re" : (word ? "R4 mem_re" : "R5 mem_re"), {31'd0, mem_re}, {31'd0, ere});
      check(word ? "R2/R4 mem_be" : "R3/R5 mem_be", {28'd0, mem_be}, {28'd0, ebe});
      check("R1 mem_addr", {18'd0, mem_addr}, 32'(wa));
      if (w) check(word ? "R2 mem_wdata" : "R3 mem_wdata", mem_wdata, ewd);
    end
    // Expected results for next cycle.
    cur = refm[wa];
    exp_lv = ere;
    exp_err = v && mis;
    exp_ld = 0;
    nxt_tag = !v ? "R8" : (mis ? "R7" : "R4");
    if (ere) begin
      if (word) begin
        exp_ld = cur;
        nxt_tag = "R4/R10";
      end else begin
        b = cur[(3-off)*8 +: 8];
        exp_ld = {{24{b[7]}}, b};
        nxt_tag = b[7] ? "R6" : "R5";
      end
    end
    if (ewe) begin
      if (word) refm[wa] = wd;
      else begin
        cur[(3-off)*8 +: 8] = wd[7:0];
        refm[wa] = cur;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 32'h9C3A_5EF1 + i * 32'h0102_0304;
      refm[i] = 32'h9C3A_5EF1 + i * 32'h0102_0304;
    end
    rdata_q = 0;
    rst = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: a load held during reset yields nothing
    check("R9 ld_valid in reset", {31'd0, ld_valid}, 0);
    check("R9 err in reset", {31'd0, err}, 0);
    req_valid = 1'b0;
    rst = 1'b0;
    nxt_tag = "R9";
    step(0, 0, 0, 0, 0);                       // R8 idle
    // Word stores and loads
    step(1, 1, 1, 16, 32'hF1E2_D3C4);
    step(1, 1, 1, 20, 32'h0123_7F80);
    step(1, 0, 1, 16, 0);
    step(1, 0, 1, 20, 0);
    // Byte loads, all offsets, mixed signs
    for (int k = 0; k < 4; k++) step(1, 0, 0, 16 + k, 0);
    for (int k = 0; k < 4; k++) step(1, 0, 0, 20 + k, 0);
    // Byte stores at each offset with word read-back (R10)
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 0, 40 + k, 32'hABCD_EF00 | 32'(k * 17));
      step(1, 0, 1, 40, 0);
    end
    // Misaligned word store and load
    for (int k = 1; k < 4; k++) begin
      step(1, 1, 1, 48 + k, 32'hDEAD_BEEF);
      step(1, 0, 1, 48 + k, 0);
    end
    step(1, 0, 1, 48, 0);                      // R7: store above wrote nothing
    // Back-to-back: load result returns while a new request is issued
    step(1, 0, 0, 17, 0);
    step(1, 1, 0, 17, 32'h0000_0055);
    step(1, 0, 0, 17, 0);
    step(1, 1, 1, 61, 32'h1);
    step(1, 0, 1, 16, 0);
    step(1, 1, 1, 16, 32'h8000_0001);
    step(1, 0, 1, 16, 0);
    // Randomized stream
    for (int n = 0; n < 600; n++) begin
      bit v, w, wd;
      int a;
      v = ($urandom % 6) != 0;
      w = $urandom % 2;
      wd = $urandom % 2;
      a = $urandom % 1024;
      if (wd && ($urandom % 5) != 0) a = a & ~3;
      step(v, w, wd, a, $urandom);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule